// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block walks a buffer of 32-bit command words in memory and turns it into writes on a register bus. A caller gives a starting word address and a length in words, then pulses `start`. The block fetches words one at a time over a request/response read port. Each command is two header words, which may be followed by payload words. Each resulting register write leaves the block with its offset, its data and a mask of the processing units that should accept it.

A unit-select command sets the unit mask that applies to every later write. Four write commands carry data: a single write, a block write at increasing offsets, a block write that repeats one offset, and a table write. A table write either holds its offset or steps through a window of a few registers and then returns to the start of the window. The stream ends cleanly when the programmed length runs out at a command boundary, or when a unit-select with an all-zero mask arrives. A malformed stream stops at once and raises `err`.

Top module: `regwr_stream_exec`

## Requirements
- R1: A unit-select command has word0 equal to 0x180AC060, and its word1 is the unit mask. Every later write carries the mask of the most recent select. Only mask bits 0 to 4 and 17 to 21 are kept, and bits 5 to 16 are cleared in `wr_unit_mask`.
- R2: A word0 with bits [30:27] = 4'b0010 is a single write. It makes one write at offset word0[19:0], and its data is word1.
- R3: A word0 with bits [30:27] = 4'b1000 is an increasing block write. Word1[13:0] gives N, and N payload words follow. Payload word k goes to offset word0[19:0] + 4k. If N is zero, no write is made.
- R4: A word0 with bits [30:27] = 4'b0110 is a repeated-offset block write. It reads a count from word1[13:0] and sends every payload word to offset word0[19:0].
- R5: A word0 with bits [30:27] = 4'b1010 is a table write. Word1[13:0] is the count, word1[19:16] is the wrap size W, and word1[31] set means the offset is held. When stepping, word k goes to base + 4·(k mod W). A W below 2 raises an error before any payload write.
- R6: A write command that comes before any unit-select raises an error. So does a second non-zero unit-select with no write command between it and the previous one.
- R7: A unit mask that sets any of bits 0 to 3 together with any of bits 17 to 20 raises an error, and no further write is made.
- R8: An opcode outside the four write codes, or a write offset with word0[1:0] not equal to zero, raises an error with no write from that command.
- R9: If the length runs out at a command boundary (a length of zero included), `done` pulses. If the length runs out inside a header or a payload, `err` pulses after the writes already made.
- R10: A unit-select with word1 equal to zero ends the stream with `done`, and no further word is requested.
- R11: `done` and `err` are one-cycle pulses and are never high together. No write follows an error. A `start` that arrives while a stream is running is ignored.
- R12: Words are requested from consecutive addresses, starting at `start_addr`. Only one request is outstanding at a time, so `rd_req` is never high in two cycles in a row.
- R13: While reset is held, and after it is released, `wr_valid`, `done`, `err` and `rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a stream (ignored while busy) |
| start_addr | input | ADDR_W | Word address of the first command word |
| start_len | input | LEN_W | Stream length in words |
| rd_req | output | 1 | Read request, one cycle |
| rd_addr | output | ADDR_W | Word address of the request |
| rd_rvalid | input | 1 | Read response valid |
| rd_rdata | input | 32 | Read response word |
| wr_valid | output | 1 | Register write strobe |
| wr_offset | output | 20 | Register offset in bytes |
| wr_data | output | 32 | Register write data |
| wr_unit_mask | output | 22 | Units that take the write |
| done | output | 1 | Stream finished cleanly (pulse) |
| err | output | 1 | Stream aborted (pulse) |

## Verification
The case that is hardest to reach from the ports is a table write whose offset must return to its base exactly at the wrap boundary. This has to be tested both at the smallest wrap size and at the largest, with a count that crosses the boundary. The stimulus table includes wrap sizes 2, 3 and 15, with counts just past one or more wraps, and the bench model works out each offset on its own. A second hard case is a `start` that arrives in the middle of a long payload. A directed test pulses `start` with a conflicting address ten cycles into a twenty-word burst, then checks that the write sequence and the outcome are unchanged.

// File: rtl/rse_pkg.sv
// Shared constants and types for the register-write stream executor.
// Assumes the command format fixed by the block: 20-bit offsets, 14-bit
// counts, 22-bit unit masks.
package rse_pkg;
    localparam int OFF_W  = 20;
    localparam int CNT_W  = 14;
    localparam int MASK_W = 22;
    localparam int WRAP_W = 4;

    localparam logic [31:0]       SEL_MARKER = 32'h180A_C060;
    localparam logic [MASK_W-1:0] MASK_KEEP  = 22'h3E_001F;

    typedef enum logic [2:0] {
        CK_SEL, CK_SINGLE, CK_INC, CK_SAME, CK_TABLE, CK_BAD
    } cmd_kind_e;

    typedef enum logic [1:0] {
        AS_INC, AS_HOLD, AS_WRAP
    } step_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_HDR0, ST_HDR1, ST_DATA
    } exec_state_e;

    typedef struct packed {
        cmd_kind_e          kind;
        logic [OFF_W-1:0]   off;
        logic [CNT_W-1:0]   cnt;
        logic [WRAP_W-1:0]  wrap;
        logic               hold;
        logic               misalign;
        logic               wrap_bad;
        logic               mask_clash;
        logic               mask_zero;
        logic [MASK_W-1:0]  mask;
    } hdr_info_t;
endpackage

// File: rtl/rse_hdr_decode.sv
// Combinational classifier for a two-word command header.
// Assumes word0 is the first header word and word1 the second; it gives
// the kind of command and every field and validity flag the sequencer needs.
module rse_hdr_decode
    import rse_pkg::*;
(
    input  logic [31:0] word0,
    input  logic [31:0] word1,
    output hdr_info_t   info
);
    logic [MASK_W-1:0] kept;

    // Keep only the unit-select bits that name a real unit
    genvar b;
    generate
        for (b = 0; b < MASK_W; b++) begin : g_keep
            assign kept[b] = word1[b] & MASK_KEEP[b];
        end
    endgenerate

    // Classify the opcode and pull out fields
    always_comb begin
        info            = '0;
        info.off        = word0[OFF_W-1:0];
        info.cnt        = word1[CNT_W-1:0];
        info.wrap       = word1[19:16];
        info.hold       = word1[31];
        info.misalign   = |word0[1:0];
        info.wrap_bad   = (word1[19:16] < 4'd2);
        info.mask       = kept;
        info.mask_zero  = (word1 == 32'd0);
        info.mask_clash = (|word1[3:0]) & (|word1[20:17]);
        if (word0 == SEL_MARKER) begin
            info.kind = CK_SEL;
        end else begin
            case (word0[30:27])
                4'b0010: info.kind = CK_SINGLE;
                4'b1000: info.kind = CK_INC;
                4'b0110: info.kind = CK_SAME;
                4'b1010: info.kind = CK_TABLE;
                default: info.kind = CK_BAD;
            endcase
        end
    end
endmodule

// File: rtl/rse_addr_seq.sv
// Target-offset sequencer for block and table writes.
// Loaded with a base, a step mode and a wrap size; each step moves to the
// offset of the next payload word. Assumes wrap >= 2 when mode is AS_WRAP.
module rse_addr_seq
    import rse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [OFF_W-1:0]   base,
    input  step_mode_e         mode,
    input  logic [WRAP_W-1:0]  wrap,
    input  logic               step,
    output logic [OFF_W-1:0]   cur
);
    logic [OFF_W-1:0]  base_q;
    logic [OFF_W-1:0]  cur_q;
    logic [WRAP_W-1:0] wrap_q;
    logic [WRAP_W-1:0] pos_q;
    step_mode_e        mode_q;

    // Track the current offset and position inside the wrap window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cur_q  <= '0;
            wrap_q <= '0;
            pos_q  <= '0;
            mode_q <= AS_HOLD;
        end else if (load) begin
            base_q <= base;
            cur_q  <= base;
            wrap_q <= wrap;
            pos_q  <= '0;
            mode_q <= mode;
        end else if (step) begin
            case (mode_q)
                AS_INC: cur_q <= cur_q + OFF_W'(4);
                AS_WRAP: begin
                    if (pos_q == wrap_q - WRAP_W'(1)) begin
                        cur_q <= base_q;
                        pos_q <= '0;
                    end else begin
                        cur_q <= cur_q + OFF_W'(4);
                        pos_q <= pos_q + WRAP_W'(1);
                    end
                end
                default: cur_q <= cur_q;
            endcase
        end
    end

    assign cur = cur_q;
endmodule

// File: rtl/rse_word_fetch.sv
// Word fetcher on a request/response read port.
// Issues one request at a time from consecutive addresses while the
// consumer pulls, and counts down the programmed length. Assumes each
// request gets exactly one response, one or more cycles later.
module rse_word_fetch #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr0,
    input  logic [LEN_W-1:0]  len,
    input  logic              pull,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rvalid,
    output logic              word_vld,
    output logic              empty
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              pend_q;

    assign rd_req   = pull & ~pend_q & (left_q != '0);
    assign rd_addr  = addr_q;
    assign word_vld = rd_rvalid & pend_q;
    assign empty    = (left_q == '0) & ~pend_q;

    // Advance the address and remaining count; track the open request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            pend_q <= 1'b0;
        end else if (load) begin
            addr_q <= addr0;
            left_q <= len;
            pend_q <= 1'b0;
        end else if (rd_req) begin
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - LEN_W'(1);
            pend_q <= 1'b1;
        end else if (rd_rvalid) begin
            pend_q <= 1'b0;
        end
    end
endmodule

// File: rtl/regwr_stream_exec.sv
// Register-write command stream executor (top).
// Fetches a command buffer, checks ordering and encodings, and emits one
// registered register write per data word. Assumes the start inputs are
// sampled only while idle; ends with a done or err pulse.
module regwr_stream_exec
    import rse_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rvalid,
    input  logic [31:0]       rd_rdata,
    output logic              wr_valid,
    output logic [19:0]       wr_offset,
    output logic [31:0]       wr_data,
    output logic [21:0]       wr_unit_mask,
    output logic              done,
    output logic              err
);
    exec_state_e       state_q, state_d;
    logic [31:0]       w0_q, w0_d;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic              sel_seen_q, sel_seen_d;
    logic              sel_last_q, sel_last_d;
    logic [CNT_W-1:0]  left_q, left_d;

    logic              pull, load_fetch, word_vld, empty;
    logic              seq_load, seq_step;
    step_mode_e        seq_mode;
    logic [OFF_W-1:0]  seq_cur;
    logic              emit, fin_ok, fin_bad;
    logic [OFF_W-1:0]  emit_off;
    hdr_info_t         info;

    logic              wr_valid_q, done_q, err_q;
    logic [OFF_W-1:0]  wr_off_q;
    logic [31:0]       wr_data_q;
    logic [MASK_W-1:0] wr_mask_q;

    rse_word_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_fetch),
        .addr0    (start_addr),
        .len      (start_len),
        .pull     (pull),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_rvalid(rd_rvalid),
        .word_vld (word_vld),
        .empty    (empty)
    );

    rse_hdr_decode u_dec (
        .word0(w0_q),
        .word1(rd_rdata),
        .info (info)
    );

    rse_addr_seq u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .load (seq_load),
        .base (info.off),
        .mode (seq_mode),
        .wrap (info.wrap),
        .step (seq_step),
        .cur  (seq_cur)
    );

    // Pick the offset step mode for the command being decoded
    always_comb begin
        case (info.kind)
            CK_INC:   seq_mode = AS_INC;
            CK_TABLE: seq_mode = info.hold ? AS_HOLD : AS_WRAP;
            default:  seq_mode = AS_HOLD;
        endcase
    end

    // Command sequencer: next state, checks and write requests
    always_comb begin
        state_d    = state_q;
        w0_d       = w0_q;
        mask_d     = mask_q;
        sel_seen_d = sel_seen_q;
        sel_last_d = sel_last_q;
        left_d     = left_q;
        pull       = (state_q != ST_IDLE);
        load_fetch = 1'b0;
        seq_load   = 1'b0;
        seq_step   = 1'b0;
        emit       = 1'b0;
        emit_off   = info.off;
        fin_ok     = 1'b0;
        fin_bad    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load_fetch = 1'b1;
                    sel_seen_d = 1'b0;
                    sel_last_d = 1'b0;
                    state_d    = ST_HDR0;
                end
            end
            ST_HDR0: begin
                if (word_vld) begin
                    w0_d    = rd_rdata;
                    state_d = ST_HDR1;
                end else if (empty) begin
                    fin_ok = 1'b1;
                end
            end
            ST_HDR1: begin
                if (word_vld) begin
                    state_d = ST_HDR0;
                    case (info.kind)
                        CK_SEL: begin
                            if (info.mask_clash) begin
                                fin_bad = 1'b1;
                            end else if (info.mask_zero) begin
                                fin_ok = 1'b1;
                            end else if (sel_last_q) begin
                                fin_bad = 1'b1;
                            end else begin
                                mask_d     = info.mask;
                                sel_seen_d = 1'b1;
                                sel_last_d = 1'b1;
                            end
                        end
                        CK_BAD: fin_bad = 1'b1;
                        default: begin
                            if (!sel_seen_q || info.misalign ||
                                (info.kind == CK_TABLE && info.wrap_bad)) begin
                                fin_bad = 1'b1;
                            end else begin
                                sel_last_d = 1'b0;
                                if (info.kind == CK_SINGLE) begin
                                    emit = 1'b1;
                                end else begin
                                    seq_load = 1'b1;
                                    left_d   = info.cnt;
                                    if (info.cnt != '0) begin
                                        state_d = ST_DATA;
                                    end
                                end
                            end
                        end
                    endcase
                end else if (empty) begin
                    fin_bad = 1'b1;
                end
            end
            ST_DATA: begin
                if (word_vld) begin
                    emit     = 1'b1;
                    emit_off = seq_cur;
                    seq_step = 1'b1;
                    left_d   = left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) begin
                        state_d = ST_HDR0;
                    end
                end else if (empty) begin
                    fin_bad = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fin_ok || fin_bad) begin
            state_d = ST_IDLE;
        end
    end

    // Sequencer state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            w0_q       <= '0;
            mask_q     <= '0;
            sel_seen_q <= 1'b0;
            sel_last_q <= 1'b0;
            left_q     <= '0;
        end else begin
            state_q    <= state_d;
            w0_q       <= w0_d;
            mask_q     <= mask_d;
            sel_seen_q <= sel_seen_d;
            sel_last_q <= sel_last_d;
            left_q     <= left_d;
        end
    end

    // Output stage: register the write and the end-of-stream pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid_q <= 1'b0;
            wr_off_q   <= '0;
            wr_data_q  <= '0;
            wr_mask_q  <= '0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            wr_valid_q <= emit;
            done_q     <= fin_ok;
            err_q      <= fin_bad;
            if (emit) begin
                wr_off_q  <= emit_off;
                wr_data_q <= rd_rdata;
                wr_mask_q <= mask_q;
            end
        end
    end

    assign wr_valid     = wr_valid_q;
    assign wr_offset    = wr_off_q;
    assign wr_data      = wr_data_q;
    assign wr_unit_mask = wr_mask_q;
    assign done         = done_q;
    assign err          = err_q;
endmodule

// File: rtl/rse_checks.sv
// Protocol checker for the stream executor, bound to the top module.
// Watches only top-level ports; assumes synchronous active-low reset.
module rse_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_req,
    input logic        wr_valid,
    input logic [19:0] wr_offset,
    input logic [21:0] wr_unit_mask,
    input logic        done,
    input logic        err
);
    // R11
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    quiet_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !wr_valid);
    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R7
    mask_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !((|wr_unit_mask[3:0]) && (|wr_unit_mask[20:17])));
    // R1
    mask_defined_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_unit_mask[16:5] == 12'd0));
    // R8
    off_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_offset[1:0] == 2'd0));
endmodule

bind regwr_stream_exec rse_checks i_rse_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_req      (rd_req),
    .wr_valid    (wr_valid),
    .wr_offset   (wr_offset),
    .wr_unit_mask(wr_unit_mask),
    .done        (done),
    .err         (err)
);

// File: tb/test_regwr_stream_exec.sv
`timescale 1ns/1ps
module test_regwr_stream_exec;
    localparam int AW = 16;
    localparam int LW = 16;
    localparam logic [31:0] SEL = 32'h180A_C060;
    localparam logic [21:0] KEEP = 22'h3E_001F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [LW-1:0] start_len = '0;
    logic          rd_req;
    logic [AW-1:0] rd_addr;
    logic          rd_rvalid = 1'b0;
    logic [31:0]   rd_rdata = '0;
    logic          wr_valid;
    logic [19:0]   wr_offset;
    logic [31:0]   wr_data;
    logic [21:0]   wr_unit_mask;
    logic          done;
    logic          err;

    always #4 clk = ~clk;

    regwr_stream_exec #(.ADDR_W(AW), .LEN_W(LW)) i_regwr_stream_exec (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_len(start_len), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata), .wr_valid(wr_valid),
        .wr_offset(wr_offset), .wr_data(wr_data), .wr_unit_mask(wr_unit_mask),
        .done(done), .err(err)
    );

    // Memory model: one-cycle read latency
    logic [31:0] mem [0:255];
    always @(posedge clk) begin
        rd_rvalid <= rd_req;
        rd_rdata  <= mem[rd_addr[7:0]];
    end

    // Monitor: log writes, reads and end pulses
    int wr_n = 0, done_n = 0, err_n = 0, rq_n = 0;
    logic [19:0] lg_off [0:511];
    logic [31:0] lg_dat [0:511];
    logic [21:0] lg_msk [0:511];
    logic [AW-1:0] lg_rda [0:511];
    always @(posedge clk) begin
        if (wr_valid) begin
            lg_off[wr_n[8:0]] <= wr_offset;
            lg_dat[wr_n[8:0]] <= wr_data;
            lg_msk[wr_n[8:0]] <= wr_unit_mask;
            wr_n <= wr_n + 1;
        end
        if (rd_req) begin
            lg_rda[rq_n[8:0]] <= rd_addr;
            rq_n <= rq_n + 1;
        end
        if (done) done_n <= done_n + 1;
        if (err)  err_n  <= err_n + 1;
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_off(input logic [31:0] h0,
                                            input logic [31:0] h1, input int k);
        int b;
        b = int'(h0[19:0]);
        case (h0[30:27])
            4'b1000: return 20'(b + 4 * k);
            4'b1010: begin
                if (h1[31]) return 20'(b);
                return 20'(b + 4 * (k % int'(h1[19:16])));
            end
            default: return 20'(b);
        endcase
    endfunction

    int w0, d0, e0, r0;

    task automatic run(input int a, input int len);
        @(negedge clk);
        w0 = wr_n; d0 = done_n; e0 = err_n; r0 = rq_n;
        start_addr = AW'(a);
        start_len  = LW'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_n != d0 || err_n != e0) break;
            @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] msk;
        logic [31:0] h0;
        logic [31:0] h1;
        logic [7:0]  npay;
        logic        bad;
        logic [7:0]  nwr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [0:NV-1] = '{
        '{4'd2, 32'h0000_000F, 32'h1000_0040, 32'hDEAD_BEEF, 8'd0,  1'b0, 8'd1},  // R2 single
        '{4'd3, 32'h0022_0000, 32'h4000_0100, 32'h0000_0005, 8'd5,  1'b0, 8'd5},  // R3 incrementing
        '{4'd4, 32'h0000_0010, 32'h3000_0200, 32'h0000_0004, 8'd4,  1'b0, 8'd4},  // R4 same offset
        '{4'd5, 32'h0002_0000, 32'h5000_0300, 32'h0003_0007, 8'd7,  1'b0, 8'd7},  // R5 wrap 3
        '{4'd5, 32'h0004_0000, 32'h5000_0400, 32'h8004_0003, 8'd3,  1'b0, 8'd3},  // R5 hold
        '{4'd5, 32'h0000_0002, 32'h5000_0800, 32'h000F_0010, 8'd16, 1'b0, 8'd16}, // R5 wrap 15
        '{4'd5, 32'h0020_0000, 32'h5000_0900, 32'h0002_0005, 8'd5,  1'b0, 8'd5},  // R5 wrap 2
        '{4'd5, 32'h0000_0001, 32'h5000_0A00, 32'h0001_0004, 8'd4,  1'b1, 8'd0},  // R5 wrap 1 bad
        '{4'd1, 32'h0001_FFE1, 32'h1000_0044, 32'h1234_5678, 8'd0,  1'b0, 8'd1},  // R1 undefined bits
        '{4'd7, 32'h0002_0001, 32'h1000_0040, 32'h0000_0001, 8'd0,  1'b1, 8'd0},  // R7 clash
        '{4'd8, 32'h0000_000F, 32'h0800_0040, 32'h0000_0001, 8'd0,  1'b1, 8'd0},  // R8 opcode
        '{4'd8, 32'h0000_000F, 32'h1000_0042, 32'h0000_0001, 8'd0,  1'b1, 8'd0},  // R8 misaligned
        '{4'd9, 32'h0000_000F, 32'h4000_0500, 32'h0000_0004, 8'd2,  1'b1, 8'd2},  // R9 short
        '{4'd3, 32'h0000_000F, 32'h4000_0600, 32'h0000_0000, 8'd0,  1'b0, 8'd0}   // R3 zero count
    };

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        repeat (3) @(negedge clk);
        // R13 reset state
        chk("R13", "wr_valid in reset", {31'd0, wr_valid}, 32'd0);
        chk("R13", "done/err/rd_req in reset", {29'd0, done, err, rd_req}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R13", "outputs after reset", {28'd0, wr_valid, done, err, rd_req}, 32'd0);

        // Table-driven walk
        for (int v = 0; v < NV; v++) begin
            string tg;
            tg = $sformatf("R%0d", VECS[v].req);
            mem[0] = SEL; mem[1] = VECS[v].msk;
            mem[2] = VECS[v].h0; mem[3] = VECS[v].h1;
            for (int i = 0; i < int'(VECS[v].npay); i++)
                mem[4 + i] = 32'hA000_0000 | (32'(v) << 8) | 32'(i);
            run(0, 4 + int'(VECS[v].npay));
            chk(tg, "done count", 32'(done_n - d0), VECS[v].bad ? 32'd0 : 32'd1);
            chk(tg, "err count", 32'(err_n - e0), VECS[v].bad ? 32'd1 : 32'd0);
            chk(tg, "write count", 32'(wr_n - w0), 32'(VECS[v].nwr));
            for (int k = 0; k < int'(VECS[v].nwr); k++) begin
                logic [31:0] ed;
                ed = (VECS[v].h0[30:27] == 4'b0010) ? VECS[v].h1 : mem[4 + k];
                chk(tg, "offset", 32'(lg_off[w0 + k]), 32'(exp_off(VECS[v].h0, VECS[v].h1, k)));
                chk(tg, "data", lg_dat[w0 + k], ed);
                chk(tg, "mask", 32'(lg_msk[w0 + k]), 32'(VECS[v].msk[21:0] & KEEP));
            end
        end

        // R6 write before any select
        mem[0] = 32'h1000_0040; mem[1] = 32'h5;
        run(0, 2);
        chk("R6", "err on write first", 32'(err_n - e0), 32'd1);
        chk("R6", "no write", 32'(wr_n - w0), 32'd0);

        // R6 two selects with no write between
        mem[0] = SEL; mem[1] = 32'h1; mem[2] = SEL; mem[3] = 32'h2;
        mem[4] = 32'h1000_0040; mem[5] = 32'h7;
        run(0, 6);
        chk("R6", "err on double select", 32'(err_n - e0), 32'd1);
        chk("R6", "no write", 32'(wr_n - w0), 32'd0);

        // R10 zero-mask terminator, R12 read addresses
        mem[40] = SEL; mem[41] = 32'h3; mem[42] = 32'h1000_0010; mem[43] = 32'hCAFE_F00D;
        mem[44] = SEL; mem[45] = 32'h0; mem[46] = 32'h1000_0020; mem[47] = 32'h1;
        run(40, 8);
        chk("R10", "done on terminator", 32'(done_n - d0), 32'd1);
        chk("R10", "no err", 32'(err_n - e0), 32'd0);
        chk("R10", "one write", 32'(wr_n - w0), 32'd1);
        chk("R10", "reads stop", 32'(rq_n - r0), 32'd6);
        for (int k = 0; k < 6; k++)
            chk("R12", "read address", 32'(lg_rda[r0 + k]), 32'(40 + k));

        // R1 mask changes between selects
        mem[60] = SEL; mem[61] = 32'h1; mem[62] = 32'h1000_0010; mem[63] = 32'h11;
        mem[64] = SEL; mem[65] = 32'h0010_0000; mem[66] = 32'h1000_0014; mem[67] = 32'h22;
        run(60, 8);
        chk("R1", "done", 32'(done_n - d0), 32'd1);
        chk("R1", "first mask", 32'(lg_msk[w0]), 32'h1);
        chk("R1", "second mask", 32'(lg_msk[w0 + 1]), 32'h0010_0000);
        chk("R1", "second offset", 32'(lg_off[w0 + 1]), 32'h14);

        // R9 zero length ends cleanly
        run(0, 0);
        chk("R9", "done on empty", 32'(done_n - d0), 32'd1);
        chk("R9", "no read", 32'(rq_n - r0), 32'd0);

        // R11 start while busy is ignored
        mem[80] = SEL; mem[81] = 32'hF; mem[82] = 32'h4000_1000; mem[83] = 32'd20;
        for (int i = 0; i < 20; i++) mem[84 + i] = 32'hB000_0000 | 32'(i);
        @(negedge clk);
        w0 = wr_n; d0 = done_n; e0 = err_n;
        start_addr = AW'(80); start_len = LW'(24); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        start_addr = AW'(0); start_len = LW'(1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            if (done_n != d0 || err_n != e0) break;
            @(negedge clk);
        end
        repeat (10) @(negedge clk);
        chk("R11", "single done", 32'(done_n - d0), 32'd1);
        chk("R11", "no err", 32'(err_n - e0), 32'd0);
        chk("R11", "write count", 32'(wr_n - w0), 32'd20);
        chk("R11", "last offset", 32'(lg_off[w0 + 19]), 32'h104C);
        chk("R11", "last data", lg_dat[w0 + 19], 32'hB000_0013);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule